// File: doc/BRIEF.md
# Period Timer with Prescaler and Postscaler

This block is an 8-bit up-counting period timer. A clock-enable input, `tick_i`, stands for the instruction clock. It first passes through a prescaler that divides by 1, 4 or 16. Each prescaled tick advances the counter. When the counter equals the period register, the next prescaled tick loads zero instead of incrementing, and the block raises `match_o` for one cycle. A neighbouring block can use that pulse as a PWM time base.

The match events are then divided by a 4-bit postscaler. Each time the postscaler completes its count, it sets a sticky interrupt flag. The flag stays set until software clears it with `flag_clr_i`.

A small register port gives access to three registers: the counter, the period and an 8-bit control word. The control word holds the postscale select, the run bit and the prescale select. Writing the counter or the control word restarts both scaler counters. Writing the control word leaves the counter value untouched.

Top module: `period_timer`

## Requirements
- R1: After reset the counter reads 0x00, the period reads 0xFF, the control word reads 0x00, and both `irq_flag_o` and `match_o` are 0.
- R2: Address 0 selects the counter, 1 the period, and 2 the control word. Address 3 reads 0x00 and ignores writes. `reg_rdata_o` follows the address combinationally. Control bit 7 always reads 0.
- R3: Control bits 1:0 select the prescale ratio: 00 divides by 1, 01 divides by 4, and 10 or 11 divides by 16.
- R4: Each prescaled tick increments the counter, except when the counter equals the period. Then the counter loads 0, and `match_o` is high in the following cycle only. A counter above the period counts on through 0xFF and wraps to 0x00 without a match.
- R5: Control bits 6:3 hold a value n. The flag is set on every (n+1)-th match event. With tick held high, the first flag after a restart from counter 0 comes after prescale×(period+1)×(n+1) cycles, and exactly n+1 match pulses are seen.
- R6: The flag holds until `flag_clr_i` is pulsed. A set event in the same cycle as a clear leaves the flag set.
- R7: A write to the counter or to the control word clears the prescale and postscale counts, and that cycle's tick is dropped. A control write does not change the counter.
- R8: With control bit 2 (run) at 0, the counter does not advance.
- R9: A write to the counter in a cycle that carries a tick loads the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable before the prescaler |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| match_o | output | 1 | One-cycle period match pulse |
| irq_flag_o | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the timer with its default widths: an 8-bit counter, a 4-bit prescale divider and a 4-bit postscale select.

It programs a period of 2, which keeps each run at no more than 768 cycles. That makes a full sweep of all four prescale codes against all sixteen postscale values affordable. Each run checks the cycle count to the first flag and the number of match pulses against an arithmetic product.

Directed sequences cover:
- the wrap above the period;
- the restart caused by a counter write and by a control write;
- the stopped timer;
- a flag set that collides with a clear.

// File: rtl/pt_pkg.sv
package pt_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ADR_COUNT  = 2'd0,
        ADR_PERIOD = 2'd1,
        ADR_CTRL   = 2'd2,
        ADR_NONE   = 2'd3
    } pt_addr_e;

    typedef struct packed {
        logic       rsvd;
        logic [3:0] post_sel;
        logic       run;
        logic [1:0] pre_sel;
    } pt_ctrl_t;

    // Terminal value of the prescale divider for a select code.
    function automatic logic [3:0] pre_last(input logic [1:0] sel);
        case (sel)
            2'b00:   pre_last = 4'd0;
            2'b01:   pre_last = 4'd3;
            default: pre_last = 4'd15;
        endcase
    endfunction

endpackage

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [1:0] sel_i,
    output logic       ptick_o
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] last;
    logic             wrap;

    assign last    = PRE_W'(pt_pkg::pre_last(sel_i));
    assign wrap    = (div_q >= last);
    assign ptick_o = tick_i & run_i & ~clr_i & wrap;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            div_q <= '0;
        end else if (tick_i && run_i) begin
            div_q <= wrap ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o,
    output logic             match_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end  = (cnt_q == period_i);
    assign hit_o   = ptick_i & ~wr_i & at_end;
    assign count_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            match_o <= 1'b0;
        end else begin
            match_o <= hit_o;
            if (wr_i) begin
                cnt_q <= wdata_i;
            end else if (ptick_i) begin
                cnt_q <= at_end ? '0 : cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pt_postscaler.sv
module pt_postscaler #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             evt_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             done_o
);
    logic [SEL_W-1:0] n_q;

    assign done_o = evt_i & ~clr_i & (n_q == sel_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            n_q <= '0;
        end else if (evt_i) begin
            n_q <= done_o ? '0 : n_q + 1'b1;
        end
    end
endmodule

// File: rtl/period_timer.sv
module period_timer #(
    parameter int CNT_W  = pt_pkg::DATA_W,
    parameter int PRE_W  = 4,
    parameter int POST_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    input  logic             flag_clr_i,
    output logic             match_o,
    output logic             irq_flag_o
);
    import pt_pkg::*;

    pt_ctrl_t         ctrl_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] count_q;
    logic             flag_q;
    logic             wr_cnt;
    logic             wr_ctl;
    logic             wr_per;
    logic             scl_clr;
    logic             ptick;
    logic             hit;
    logic             flag_set;
    logic             run_q;

    assign wr_cnt  = reg_we_i && (pt_addr_e'(reg_addr_i) == ADR_COUNT);
    assign wr_per  = reg_we_i && (pt_addr_e'(reg_addr_i) == ADR_PERIOD);
    assign wr_ctl  = reg_we_i && (pt_addr_e'(reg_addr_i) == ADR_CTRL);
    assign scl_clr = wr_cnt | wr_ctl;
    assign run_q   = ctrl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '1;
        end else begin
            if (wr_ctl) begin
                ctrl_q      <= pt_ctrl_t'(reg_wdata_i[7:0]);
                ctrl_q.rsvd <= 1'b0;
            end
            if (wr_per) begin
                period_q <= reg_wdata_i;
            end
        end
    end

    pt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .run_i   (ctrl_q.run),
        .clr_i   (scl_clr),
        .sel_i   (ctrl_q.pre_sel),
        .ptick_o (ptick)
    );

    pt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ptick_i  (ptick),
        .wr_i     (wr_cnt),
        .wdata_i  (reg_wdata_i),
        .period_i (period_q),
        .count_o  (count_q),
        .hit_o    (hit),
        .match_o  (match_o)
    );

    pt_postscaler #(.SEL_W(POST_W)) u_post (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (scl_clr),
        .evt_i  (hit),
        .sel_i  (POST_W'(ctrl_q.post_sel)),
        .done_o (flag_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (flag_set) begin
            flag_q <= 1'b1;
        end else if (flag_clr_i) begin
            flag_q <= 1'b0;
        end
    end
    assign irq_flag_o = flag_q;

    always_comb begin
        case (pt_addr_e'(reg_addr_i))
            ADR_COUNT:  reg_rdata_o = count_q;
            ADR_PERIOD: reg_rdata_o = period_q;
            ADR_CTRL:   reg_rdata_o = CNT_W'(ctrl_q);
            default:    reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pt_checker.sv
module pt_checker (
    input logic       clk,
    input logic       rst,
    input logic       reg_we_i,
    input logic [1:0] reg_addr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       flag_clr_i,
    input logic       match_o,
    input logic       irq_flag_o,
    input logic [7:0] count_q,
    input logic       run_q,
    input logic       flag_set
);
    a_r4_match_zero: assert property (@(posedge clk) disable iff (rst)
        match_o |-> count_q == 8'd0);

    a_r2_ctrl_top_bit: assert property (@(posedge clk) disable iff (rst)
        reg_addr_i == 2'd2 |-> reg_rdata_o[7] == 1'b0);

    a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
        irq_flag_o && !flag_clr_i |=> irq_flag_o);

    a_r6_clear_alone: assert property (@(posedge clk) disable iff (rst)
        flag_clr_i && !flag_set |=> !irq_flag_o);

    a_r5_flag_with_match: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag_o) |-> match_o);

    a_r8_stopped: assert property (@(posedge clk) disable iff (rst)
        !run_q && !(reg_we_i && reg_addr_i == 2'd0) |=> $stable(count_q));

    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        reg_we_i && reg_addr_i == 2'd0 |=> count_q == $past(reg_wdata_i));
endmodule

bind period_timer pt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .flag_clr_i  (flag_clr_i),
    .match_o     (match_o),
    .irq_flag_o  (irq_flag_o),
    .count_q     (count_q),
    .run_q       (run_q),
    .flag_set    (flag_set)
);

// File: tb/period_timer_test.sv
module period_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       reg_we_i = 1'b0;
    logic [1:0] reg_addr_i = 2'd0;
    logic [7:0] reg_wdata_i = 8'd0;
    logic [7:0] reg_rdata_o;
    logic       flag_clr_i = 1'b0;
    logic       match_o;
    logic       irq_flag_o;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    period_timer uut (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .flag_clr_i  (flag_clr_i),
        .match_o     (match_o),
        .irq_flag_o  (irq_flag_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check(d == 8'h00, "R1 count", d, 0);
        rd(2'd1, d); check(d == 8'hFF, "R1 period", d, 255);
        rd(2'd2, d); check(d == 8'h00, "R1 ctrl", d, 0);
        check(irq_flag_o == 1'b0, "R1 flag", irq_flag_o, 0);
        check(match_o == 1'b0, "R1 match", match_o, 0);

        // R2 register map
        wr(2'd1, 8'h5A); rd(2'd1, d); check(d == 8'h5A, "R2 period rw", d, 8'h5A);
        wr(2'd0, 8'h33); rd(2'd0, d); check(d == 8'h33, "R2 count rw", d, 8'h33);
        wr(2'd2, 8'hFF); rd(2'd2, d); check(d == 8'h7F, "R2 ctrl bit7", d, 8'h7F);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h55); rd(2'd3, d); check(d == 8'h00, "R2 addr3", d, 0);
        rd(2'd0, d); check(d == 8'h33, "R2 addr3 no effect", d, 8'h33);

        // R8 stopped timer
        ticks(10); rd(2'd0, d); check(d == 8'h33, "R8 stopped", d, 8'h33);

        // R7 scaler restart by control write and counter write (prescale 4)
        wr(2'd2, 8'b0_0000_1_01); wr(2'd0, 8'h10);
        ticks(3); rd(2'd0, d); check(d == 8'h10, "R3 div4 partial", d, 8'h10);
        wr(2'd2, 8'b0_0000_1_01); rd(2'd0, d); check(d == 8'h10, "R7 ctrl keeps count", d, 8'h10);
        ticks(3); rd(2'd0, d); check(d == 8'h10, "R7 ctrl restart", d, 8'h10);
        ticks(1); rd(2'd0, d); check(d == 8'h11, "R3 div4 step", d, 8'h11);
        ticks(3); wr(2'd0, 8'h20);
        ticks(3); rd(2'd0, d); check(d == 8'h20, "R7 count restart", d, 8'h20);
        ticks(1); rd(2'd0, d); check(d == 8'h21, "R7 count step", d, 8'h21);

        // R9 write in a tick cycle
        wr(2'd2, 8'b0_0000_1_00);
        tick_i = 1'b1; wr(2'd0, 8'h40); tick_i = 1'b0;
        rd(2'd0, d); check(d == 8'h40, "R9 write wins", d, 8'h40);

        // R4 wrap above period, then match
        wr(2'd1, 8'd5); wr(2'd0, 8'hFE);
        ticks(1); rd(2'd0, d); check(d == 8'hFF && !match_o, "R4 to FF", d, 255);
        ticks(1); rd(2'd0, d); check(d == 8'h00 && !match_o, "R4 wrap", d, 0);
        ticks(5); rd(2'd0, d); check(d == 8'd5, "R4 at period", d, 5);
        ticks(1); rd(2'd0, d);
        check(d == 8'h00, "R4 reload", d, 0);
        check(match_o == 1'b1, "R4 match pulse", match_o, 1);
        @(negedge clk); check(match_o == 1'b0, "R4 match one cycle", match_o, 0);

        // R6 set beats clear
        clr_flag();
        wr(2'd1, 8'd3); wr(2'd2, 8'b0_0000_1_00); wr(2'd0, 8'd0);
        ticks(3);
        tick_i = 1'b1; flag_clr_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0; flag_clr_i = 1'b0;
        check(irq_flag_o == 1'b1, "R6 set beats clear", irq_flag_o, 1);
        repeat (4) @(negedge clk);
        check(irq_flag_o == 1'b1, "R6 holds", irq_flag_o, 1);
        clr_flag();
        check(irq_flag_o == 1'b0, "R6 cleared", irq_flag_o, 0);

        // R3/R5 sweep over all prescale codes and postscale values
        for (int ps = 0; ps < 4; ps++) begin
            for (int po = 0; po < 16; po++) begin
                int pre;
                int expn;
                int n;
                int nm;
                pre  = (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
                expn = pre * 3 * (po + 1);
                wr(2'd1, 8'd2);
                wr(2'd2, {1'b0, 4'(po), 1'b1, 2'(ps)});
                wr(2'd0, 8'd0);
                clr_flag();
                check(irq_flag_o == 1'b0, "R6 clear before run", irq_flag_o, 0);
                n = 0; nm = 0;
                tick_i = 1'b1;
                while (n < 1000) begin
                    @(negedge clk);
                    n++;
                    if (match_o) nm++;
                    if (irq_flag_o) break;
                end
                tick_i = 1'b0;
                check(n == expn, "R5 R3 cycles to flag", n, expn);
                check(nm == po + 1, "R5 match pulses", nm, po + 1);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule